// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a clock by a programmable ratio N = B·P + A and emits one single-cycle pulse per N input cycles, for use as the feedback branch of a phase-locked loop. The input clock drives a prescaler that divides by either P or P+1. Two counters sit behind the prescaler. The swallow counter A holds the prescaler at P+1 for its first A prescaler cycles. The main counter B counts every prescaler cycle and marks the end of the frame. At that point both counters reload together.

The prescaler modulus P is chosen by a 2-bit select. Two controls return the counters to their load point: a counter-hold input and a power-down input. While either is high no pulse is produced, and counting resumes when both are low. New A, B and select values are read only at a reload, so no frame is ever divided by a mixed ratio. A combinational flag reports a configuration that cannot be divided correctly.

The block has no streaming data path. All of its pins are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `pulse_swallow_div`

## Requirements
- R1: In steady counting, `div_pulse` is high for exactly one cycle, and successive pulses are exactly N = B·P + A input clock cycles apart.
- R2: The prescaler select encodes P as follows: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. The prescaler divides by P+1 while modulus control is high and by P otherwise.
- R3: `mod_hi` is high while the swallow count is nonzero. After a load with A > 0 it stays high for exactly A·(P+1) input cycles and then falls. With A = 0 it stays low.
- R4: When the hold and power-down inputs fall, the first pulse is sampled after exactly N rising edges.
- R5: While `cnt_hold` is high, `div_pulse` stays low and the counters sit at their load values.
- R6: While `pwr_dn` is high, `div_pulse` stays low and the counters sit at their load values. Counting resumes with a full frame when it falls.
- R7: A change to `cfg_a`, `cfg_b` or `cfg_psel` during a frame does not affect that frame. The new ratio applies from the next frame onward.
- R8: `cfg_err` is high when `cfg_b` < 3 or `cfg_a` > `cfg_b`, and low otherwise.
- R9: During reset `div_pulse` is low. After reset is released, the first edge loads the counters and the first pulse follows N+1 edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_a | input | 6 | Swallow count A (0..63) |
| cfg_b | input | 13 | Main count B (3..8191) |
| cfg_psel | input | 2 | Prescaler select (00=8, 01=16, 10=32, 11=64) |
| cnt_hold | input | 1 | Hold counters at load point |
| pwr_dn | input | 1 | Power-down: counters forced to load state |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| mod_hi | output | 1 | Modulus control, high selects P+1 |
| cfg_err | output | 1 | Configuration cannot be divided correctly |

## Verification
The assertions take for granted that the configuration is legal whenever counting runs: B ≥ 3 and A ≤ B, so that N is at least 24 and pulses can never be adjacent. The stimulus sets illegal values only while `cnt_hold` is high, and it changes configuration in the middle of a frame only to check that the change is deferred. All inputs are driven on the falling clock edge, so the single clock domain sees them stable at each rising edge.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned A_W    = 6;
  localparam int unsigned B_W    = 13;
  localparam int unsigned PSEL_W = 2;
  localparam int unsigned BASE_P = 8;
  localparam int unsigned P_MAX  = BASE_P << ((1 << PSEL_W) - 1);
  localparam int unsigned PC_W   = $clog2(P_MAX + 2);

  function automatic logic [PC_W-1:0] modulus_of(input logic [PSEL_W-1:0] sel);
    logic [PC_W-1:0] base;
    base = PC_W'(BASE_P);
    return base << sel;
  endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [PC_W-1:0] p_val,
  input  logic            mod_hi,
  output logic            tick
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] lim;

  assign lim  = p_val + PC_W'(mod_hi);
  assign tick = (pc == lim - PC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (clr)  pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + PC_W'(1);
  end

  // R2: each prescaler cycle restarts from zero
  a_r2_pre_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (pc == '0));
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
  import psd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              tick,
  input  logic [A_W-1:0]    cfg_a,
  input  logic [B_W-1:0]    cfg_b,
  input  logic [PSEL_W-1:0] cfg_psel,
  output logic [PC_W-1:0]   p_val,
  output logic              mod_hi,
  output logic              frame_end
);
  logic [A_W-1:0]    a_cnt;
  logic [B_W-1:0]    b_cnt;
  logic [PSEL_W-1:0] psel_q;
  logic              last;

  assign last      = (b_cnt <= B_W'(1));
  assign mod_hi    = (a_cnt != '0);
  assign p_val     = modulus_of(psel_q);
  assign frame_end = tick && last && !ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt  <= '0;
      b_cnt  <= '0;
      psel_q <= '0;
    end else if (ld || (tick && last)) begin
      a_cnt  <= cfg_a;
      b_cnt  <= cfg_b;
      psel_q <= cfg_psel;
    end else if (tick) begin
      b_cnt <= b_cnt - B_W'(1);
      if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
    end
  end

  // R3: modulus control changes only at a prescaler boundary or a load
  a_r3_mod_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(mod_hi));
  // R7: the active modulus changes only at a reload
  a_r7_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !(tick && last)) |=> $stable(p_val));
endmodule

// File: rtl/psd_cfg_check.sv
module psd_cfg_check
  import psd_pkg::*;
(
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  output logic           bad
);
  localparam int unsigned B_MIN = 3;
  always_comb bad = (cfg_b < B_W'(B_MIN)) || (B_W'(cfg_a) > cfg_b);
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
(
  input  logic        clk_in,
  input  logic        rst_n,
  input  logic [5:0]  cfg_a,
  input  logic [12:0] cfg_b,
  input  logic [1:0]  cfg_psel,
  input  logic        cnt_hold,
  input  logic        pwr_dn,
  output logic        div_pulse,
  output logic        mod_hi,
  output logic        cfg_err
);
  logic            live;
  logic            ld;
  logic            tick;
  logic            frame_end;
  logic [PC_W-1:0] p_val;

  assign ld = !live || cnt_hold || pwr_dn;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      live      <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      live      <= 1'b1;
      div_pulse <= frame_end;
    end
  end

  psd_prescaler u_pre (
    .clk(clk_in), .rst_n(rst_n), .clr(ld),
    .p_val(p_val), .mod_hi(mod_hi), .tick(tick)
  );

  psd_swallow u_cnt (
    .clk(clk_in), .rst_n(rst_n), .ld(ld), .tick(tick),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_psel(cfg_psel),
    .p_val(p_val), .mod_hi(mod_hi), .frame_end(frame_end)
  );

  psd_cfg_check u_chk (.cfg_a(cfg_a), .cfg_b(cfg_b), .bad(cfg_err));

  // R1: pulses are single-cycle
  a_r1_pulse_single: assert property (@(posedge clk_in) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  // R5: no pulse while held
  a_r5_hold_quiet: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt_hold |=> !div_pulse);
  // R6: no pulse while powered down
  a_r6_pd_quiet: assert property (@(posedge clk_in) disable iff (!rst_n)
    pwr_dn |=> !div_pulse);
endmodule

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_a;
  logic [12:0] cfg_b;
  logic [1:0]  cfg_psel;
  logic        cnt_hold, pwr_dn;
  logic        div_pulse, mod_hi, cfg_err;
  int          checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  pulse_swallow_div i_pulse_swallow_div (
    .clk_in(clk), .rst_n(rst_n), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .cfg_psel(cfg_psel), .cnt_hold(cnt_hold), .pwr_dn(pwr_dn),
    .div_pulse(div_pulse), .mod_hi(mod_hi), .cfg_err(cfg_err)
  );

  // psel, A, B, expected N = B*P + A with P = 8 << psel
  localparam int VEC [7][4] = '{
    '{0,  0,  3,   24},
    '{0,  3,  3,   27},
    '{1,  5,  7,  117},
    '{2,  2,  4,  130},
    '{3, 10, 10,  650},
    '{0, 63, 63,  567},
    '{3,  0, 20, 1280}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count rising edges until div_pulse is sampled high
  task automatic wait_pulse(output int k);
    k = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (div_pulse) return;
    end
    k = -1;
  endtask

  task automatic load(input int ps, input int a, input int b);
    cfg_psel = 2'(ps); cfg_a = 6'(a); cfg_b = 13'(b);
    cnt_hold = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, hi;
    rst_n = 1'b0; cnt_hold = 1'b0; pwr_dn = 1'b0;
    cfg_psel = 2'd0; cfg_a = 6'd0; cfg_b = 13'd3;
    repeat (3) @(negedge clk);
    chk("R9 reset pulse low", int'(div_pulse), 0);
    rst_n = 1'b1;
    wait_pulse(k);
    chk("R9 first pulse after reset", k, 25);

    // vector table: R1 R2 R3 R4
    for (int v = 0; v < 7; v++) begin
      load(VEC[v][0], VEC[v][1], VEC[v][2]);
      chk("R3 mod_hi at load", int'(mod_hi), int'(VEC[v][1] != 0));
      cnt_hold = 1'b0;
      wait_pulse(k);
      chk("R4 first frame length", k, VEC[v][3]);
      wait_pulse(k);
      chk("R1 R2 period", k, VEC[v][3]);
      @(posedge clk); @(negedge clk);
      chk("R1 single-cycle pulse", int'(div_pulse), 0);
    end

    // R3: swallow phase lasts A*(P+1) cycles (A=3, P=8 -> 27)
    load(0, 3, 5);
    cnt_hold = 1'b0;
    repeat (26) begin @(posedge clk); @(negedge clk); end
    chk("R3 mod_hi during swallow", int'(mod_hi), 1);
    @(posedge clk); @(negedge clk);
    chk("R3 mod_hi after swallow", int'(mod_hi), 0);

    // R7: config change mid-frame deferred to reload
    load(0, 0, 3);
    cnt_hold = 1'b0;
    wait_pulse(k);
    cfg_psel = 2'd1; cfg_a = 6'd5; cfg_b = 13'd7;
    wait_pulse(k);
    chk("R7 current frame keeps old ratio", k, 24);
    wait_pulse(k);
    chk("R7 next frame uses new ratio", k, 117);

    // R5: hold keeps counters at load point
    cnt_hold = 1'b1;
    hi = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); @(negedge clk);
      if (div_pulse) hi++;
    end
    chk("R5 no pulse while held", hi, 0);
    chk("R5 load state mod_hi", int'(mod_hi), 1);
    cnt_hold = 1'b0;
    wait_pulse(k);
    chk("R5 full frame after hold", k, 117);

    // R6: power-down mid-frame
    repeat (40) @(negedge clk);
    pwr_dn = 1'b1;
    hi = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); @(negedge clk);
      if (div_pulse) hi++;
    end
    chk("R6 no pulse while powered down", hi, 0);
    pwr_dn = 1'b0;
    wait_pulse(k);
    chk("R6 full frame after power-up", k, 117);

    // R8: configuration flag
    cnt_hold = 1'b1;
    cfg_a = 6'd0; cfg_b = 13'd2; @(negedge clk);
    chk("R8 B below 3", int'(cfg_err), 1);
    cfg_a = 6'd5; cfg_b = 13'd4; @(negedge clk);
    chk("R8 A above B", int'(cfg_err), 1);
    cfg_a = 6'd4; cfg_b = 13'd4; @(negedge clk);
    chk("R8 A equal B", int'(cfg_err), 0);
    cfg_a = 6'd0; cfg_b = 13'd3; @(negedge clk);
    chk("R8 minimum B", int'(cfg_err), 0);
    @(negedge clk);
    chk("R5 held with bad cfg no pulse", int'(div_pulse), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule